// File: doc/BRIEF.md
# Shift and Rotate Unit with Flag Update

This block performs the seven shift and rotate operations of a general-purpose integer pipeline on one operand word: rotate left and right, rotate left and right through the carry flag, logical shift left, logical shift right and arithmetic shift right. The shift distance can come from an 8-bit immediate, from an 8-bit count register, or it can be forced to one. In every case only the low five bits of the distance are used, so the distance is 0 to 31 for the default 32-bit word.

A request is presented with `opValid` high for one cycle. One clock edge later the unit shows the result with a write strobe, the updated flags and one update strobe per flag. The unit keeps its own copy of the six flags (carry, overflow, sign, zero, adjust and parity). A flag keeps its value unless its strobe fires. If the effective distance is zero, nothing is written and no flag moves. Rotates touch only carry and overflow. Shifts set all six flags, and the adjust flag is always driven to 0.

The operation code is 3 bits: 000 rotate left, 001 rotate right, 010 rotate left through carry, 011 rotate right through carry, 100 shift left, 101 logical shift right, 111 arithmetic shift right. Code 110 acts as a second spelling of shift left. The count source is 2 bits: 00 immediate, 01 constant one, 10 and 11 count register.

Top module: `shift_rot_unit`

## Requirements
- R1: The effective distance is the low 5 bits of `immCount` when `cntSrc`=00, exactly 1 when `cntSrc`=01 (whatever `immCount` holds), and the low 5 bits of `cntReg` when `cntSrc` is 10 or 11.
- R2: When the effective distance is 0, `resultWe` and every flag strobe stay low, and `result` and all flag outputs keep their previous values.
- R3: All outputs change exactly one clock edge after a cycle with `opValid` high. A cycle with `opValid` low raises no strobe and changes no output.
- R4: Rotate left (000) gives the operand rotated left by the distance. CF becomes result bit 0, and OF becomes CF XOR result bit 31.
- R5: Rotate right (001) gives the operand rotated right by the distance. CF becomes result bit 31, and OF becomes result bit 31 XOR result bit 30.
- R6: Rotate left through carry (010) rotates the 33-bit value {carryIn, operand} left by the distance. Old carry lands at bit distance-1, new CF is operand bit 32-distance, and OF is new CF XOR result bit 31.
- R7: Rotate right through carry (011) rotates {carryIn, operand} right by the distance. Old carry lands at bit 32-distance, new CF is operand bit distance-1, and OF is result bit 31 XOR result bit 30.
- R8: Shift left (100, and 110 alike) fills with zeros. CF is the last bit shifted out, operand bit 32-distance, and OF is result bit 31 XOR CF.
- R9: Logical shift right (101) fills with zeros. CF is operand bit distance-1, and OF is operand bit 31.
- R10: Arithmetic shift right (111) fills the vacated upper bits with operand bit 31. CF is operand bit distance-1, and OF is 0.
- R11: For shifts, SF is result bit 31, ZF is 1 when the result is zero, PF is 1 when the low 8 result bits hold an even number of ones, and AF is 0.
- R12: A rotate with nonzero distance raises only the CF and OF strobes and leaves SF, ZF, AF and PF unchanged. A shift with nonzero distance raises all six strobes. A flag output changes only in a cycle where its strobe is high.
- R13: After reset, `result`, `resultWe`, all flag outputs and all strobes are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| opValid | input | 1 | Request strobe, one cycle per operation |
| opSel | input | 3 | Operation code |
| cntSrc | input | 2 | Distance source select |
| immCount | input | 8 | Immediate distance |
| cntReg | input | 8 | Count register distance |
| operand | input | 32 | Operand word |
| carryIn | input | 1 | Incoming carry flag |
| result | output | 32 | Result word, held between writes |
| resultWe | output | 1 | Result write strobe |
| cfOut | output | 1 | Carry flag |
| ofOut | output | 1 | Overflow flag |
| sfOut | output | 1 | Sign flag |
| zfOut | output | 1 | Zero flag |
| afOut | output | 1 | Adjust flag |
| pfOut | output | 1 | Parity flag |
| cfWe | output | 1 | Carry flag update strobe |
| ofWe | output | 1 | Overflow flag update strobe |
| sfWe | output | 1 | Sign flag update strobe |
| zfWe | output | 1 | Zero flag update strobe |
| afWe | output | 1 | Adjust flag update strobe |
| pfWe | output | 1 | Parity flag update strobe |

## Verification
Each operation code is swept through all 32 distances from the count register. Each distance uses random operands, random upper register bits and both carry values. This separates the two rotate kinds from the through-carry kinds and shows whether the carry enters at the right position. Operands with bit 31 set and clear tell arithmetic from logical right shift. Zero results and operands of known parity check the ZF and PF rules. Further sequences cover immediate distances with junk in the upper bits, the forced distance of one, zero distances from both sources, and idle cycles. A shift followed by a rotate shows that flags are held when their strobes stay low.

// File: rtl/sru_pkg.sv
package sru_pkg;

  typedef enum logic [2:0] {
    OP_ROL  = 3'b000,
    OP_ROR  = 3'b001,
    OP_RCL  = 3'b010,
    OP_RCR  = 3'b011,
    OP_SHL  = 3'b100,
    OP_SHR  = 3'b101,
    OP_SHL2 = 3'b110,
    OP_SAR  = 3'b111
  } srOp_e;

  typedef enum logic [1:0] {
    CNT_IMM  = 2'b00,
    CNT_ONE  = 2'b01,
    CNT_REG  = 2'b10,
    CNT_REG2 = 2'b11
  } cntSrc_e;

  // strobes from control to datapath
  typedef struct packed {
    logic  writeEn;
    logic  rotFlags;
    logic  shiftFlags;
    srOp_e kind;
  } srStrobe_t;

  // flag vector, order {cf, of, sf, zf, af, pf}
  typedef struct packed {
    logic cf;
    logic of;
    logic sf;
    logic zf;
    logic af;
    logic pf;
  } srFlags_t;

endpackage

// File: rtl/sru_ctrl.sv
module sru_ctrl
  import sru_pkg::*;
#(
  parameter int WIDTH    = 32,
  parameter int IMM_BITS = 8,
  localparam int CNT_BITS = $clog2(WIDTH)
) (
  input  logic                opValid,
  input  logic [2:0]          opSel,
  input  logic [1:0]          cntSrc,
  input  logic [IMM_BITS-1:0] immCount,
  input  logic [IMM_BITS-1:0] cntReg,
  output srStrobe_t           strobe,
  output logic [CNT_BITS-1:0] count
);

  // upper distance bits are masked away on purpose
  logic unusedHiBits;
  assign unusedHiBits = ^{immCount[IMM_BITS-1:CNT_BITS], cntReg[IMM_BITS-1:CNT_BITS]};

  always_comb begin
    unique case (cntSrc_e'(cntSrc))
      CNT_IMM:  count = immCount[CNT_BITS-1:0];
      CNT_ONE:  count = CNT_BITS'(1);
      default:  count = cntReg[CNT_BITS-1:0];
    endcase
  end

  logic doWrite;
  assign doWrite = opValid && (count != '0);

  always_comb begin
    strobe.writeEn    = doWrite;
    strobe.rotFlags   = doWrite && !opSel[2];
    strobe.shiftFlags = doWrite && opSel[2];
    strobe.kind       = srOp_e'(opSel);
  end

endmodule

// File: rtl/sru_datapath.sv
module sru_datapath
  import sru_pkg::*;
#(
  parameter int WIDTH = 32,
  localparam int CNT_BITS = $clog2(WIDTH),
  localparam int AMT_BITS = CNT_BITS + 1
) (
  input  logic                clk,
  input  logic                rstN,
  input  srStrobe_t           strobe,
  input  logic [CNT_BITS-1:0] count,
  input  logic [WIDTH-1:0]    operand,
  input  logic                carryIn,
  output logic [WIDTH-1:0]    result,
  output logic                resultWe,
  output srFlags_t            flags,
  output srFlags_t            flagWe
);

  // complementary distances for the two-sided rotate form
  logic [AMT_BITS-1:0] amt, amtComp, amtCompC;
  assign amt      = AMT_BITS'(count);
  assign amtComp  = AMT_BITS'(WIDTH) - amt;
  assign amtCompC = AMT_BITS'(WIDTH + 1) - amt;

  // plain rotates
  logic [WIDTH-1:0] rolRes, rorRes;
  assign rolRes = (operand << amt) | (operand >> amtComp);
  assign rorRes = (operand >> amt) | (operand << amtComp);

  // rotates through carry on {carry, operand}
  logic [WIDTH:0] extWord, rclWord, rcrWord;
  assign extWord = {carryIn, operand};
  assign rclWord = (extWord << amt) | (extWord >> amtCompC);
  assign rcrWord = (extWord >> amt) | (extWord << amtCompC);

  // shifts with one guard bit catching the last bit out
  logic [WIDTH:0] shlWord, shrWord, sarWord;
  assign shlWord = {1'b0, operand} << amt;
  assign shrWord = {operand, 1'b0} >> amt;
  assign sarWord = (WIDTH+1)'($signed({operand, 1'b0}) >>> amt);

  // even parity over the low byte, built bit by bit
  localparam int PAR_BITS = (WIDTH < 8) ? WIDTH : 8;
  logic [WIDTH-1:0]    nxtRes;
  logic [PAR_BITS:0]   parChain;
  assign parChain[0] = 1'b1;
  for (genvar gi = 0; gi < PAR_BITS; gi++) begin : gPar
    assign parChain[gi+1] = parChain[gi] ^ nxtRes[gi];
  end

  logic nxtCf, nxtOf;

  always_comb begin
    nxtRes = operand;
    nxtCf  = 1'b0;
    nxtOf  = 1'b0;
    unique case (strobe.kind)
      OP_ROL: begin
        nxtRes = rolRes;
        nxtCf  = rolRes[0];
        nxtOf  = rolRes[0] ^ rolRes[WIDTH-1];
      end
      OP_ROR: begin
        nxtRes = rorRes;
        nxtCf  = rorRes[WIDTH-1];
        nxtOf  = rorRes[WIDTH-1] ^ rorRes[WIDTH-2];
      end
      OP_RCL: begin
        nxtRes = rclWord[WIDTH-1:0];
        nxtCf  = rclWord[WIDTH];
        nxtOf  = rclWord[WIDTH] ^ rclWord[WIDTH-1];
      end
      OP_RCR: begin
        nxtRes = rcrWord[WIDTH-1:0];
        nxtCf  = rcrWord[WIDTH];
        nxtOf  = rcrWord[WIDTH-1] ^ rcrWord[WIDTH-2];
      end
      OP_SHL, OP_SHL2: begin
        nxtRes = shlWord[WIDTH-1:0];
        nxtCf  = shlWord[WIDTH];
        nxtOf  = shlWord[WIDTH] ^ shlWord[WIDTH-1];
      end
      OP_SHR: begin
        nxtRes = shrWord[WIDTH:1];
        nxtCf  = shrWord[0];
        nxtOf  = operand[WIDTH-1];
      end
      default: begin
        nxtRes = sarWord[WIDTH:1];
        nxtCf  = sarWord[0];
        nxtOf  = 1'b0;
      end
    endcase
  end

  srFlags_t nxtFlags, nxtWe;
  always_comb begin
    nxtFlags.cf = nxtCf;
    nxtFlags.of = nxtOf;
    nxtFlags.sf = nxtRes[WIDTH-1];
    nxtFlags.zf = (nxtRes == '0);
    nxtFlags.af = 1'b0;
    nxtFlags.pf = parChain[PAR_BITS];
    nxtWe.cf    = strobe.rotFlags || strobe.shiftFlags;
    nxtWe.of    = strobe.rotFlags || strobe.shiftFlags;
    nxtWe.sf    = strobe.shiftFlags;
    nxtWe.zf    = strobe.shiftFlags;
    nxtWe.af    = strobe.shiftFlags;
    nxtWe.pf    = strobe.shiftFlags;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      result   <= '0;
      resultWe <= 1'b0;
    end else begin
      resultWe <= strobe.writeEn;
      if (strobe.writeEn) result <= nxtRes;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      flags  <= '0;
      flagWe <= '0;
    end else begin
      flagWe <= nxtWe;
      flags  <= (nxtFlags & nxtWe) | (flags & ~nxtWe);
    end
  end

endmodule

// File: rtl/shift_rot_unit.sv
module shift_rot_unit
  import sru_pkg::*;
#(
  parameter int WIDTH    = 32,
  parameter int IMM_BITS = 8
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                opValid,
  input  logic [2:0]          opSel,
  input  logic [1:0]          cntSrc,
  input  logic [IMM_BITS-1:0] immCount,
  input  logic [IMM_BITS-1:0] cntReg,
  input  logic [WIDTH-1:0]    operand,
  input  logic                carryIn,
  output logic [WIDTH-1:0]    result,
  output logic                resultWe,
  output logic                cfOut,
  output logic                ofOut,
  output logic                sfOut,
  output logic                zfOut,
  output logic                afOut,
  output logic                pfOut,
  output logic                cfWe,
  output logic                ofWe,
  output logic                sfWe,
  output logic                zfWe,
  output logic                afWe,
  output logic                pfWe
);

  localparam int CNT_BITS = $clog2(WIDTH);

  srStrobe_t           strobe;
  logic [CNT_BITS-1:0] count;
  srFlags_t            flags, flagWe;

  sru_ctrl #(.WIDTH(WIDTH), .IMM_BITS(IMM_BITS)) uCtrl (
    .opValid (opValid),
    .opSel   (opSel),
    .cntSrc  (cntSrc),
    .immCount(immCount),
    .cntReg  (cntReg),
    .strobe  (strobe),
    .count   (count)
  );

  sru_datapath #(.WIDTH(WIDTH)) uData (
    .clk     (clk),
    .rstN    (rstN),
    .strobe  (strobe),
    .count   (count),
    .operand (operand),
    .carryIn (carryIn),
    .result  (result),
    .resultWe(resultWe),
    .flags   (flags),
    .flagWe  (flagWe)
  );

  assign {cfOut, ofOut, sfOut, zfOut, afOut, pfOut} = flags;
  assign {cfWe, ofWe, sfWe, zfWe, afWe, pfWe}       = flagWe;

endmodule

// File: rtl/sru_checker.sv
module sru_checker #(
  parameter int WIDTH    = 32,
  parameter int IMM_BITS = 8
) (
  input logic                clk,
  input logic                rstN,
  input logic                opValid,
  input logic [2:0]          opSel,
  input logic [1:0]          cntSrc,
  input logic [IMM_BITS-1:0] immCount,
  input logic [WIDTH-1:0]    result,
  input logic                resultWe,
  input logic                cfOut,
  input logic                ofOut,
  input logic                sfOut,
  input logic                afOut,
  input logic                cfWe,
  input logic                ofWe,
  input logic                sfWe,
  input logic                zfWe,
  input logic                afWe,
  input logic                pfWe
);

  localparam int CNT_BITS = $clog2(WIDTH);

  // R3
  write_needs_request_chk: assert property (@(posedge clk) disable iff (!rstN)
    resultWe |-> $past(opValid));

  // R2
  zero_imm_quiet_chk: assert property (@(posedge clk) disable iff (!rstN)
    (opValid && cntSrc == 2'b00 && immCount[CNT_BITS-1:0] == '0) |=> (!resultWe && !cfWe && !ofWe && !sfWe));

  // R4
  rol_flags_chk: assert property (@(posedge clk) disable iff (!rstN)
    (resultWe && $past(opSel) == 3'b000) |-> (cfOut == result[0] && ofOut == (result[0] ^ result[WIDTH-1])));

  // R5
  ror_flags_chk: assert property (@(posedge clk) disable iff (!rstN)
    (resultWe && $past(opSel) == 3'b001) |-> (cfOut == result[WIDTH-1] && ofOut == (result[WIDTH-1] ^ result[WIDTH-2])));

  // R11
  adjust_zero_chk: assert property (@(posedge clk) disable iff (!rstN)
    afWe |-> !afOut);

  // R12
  rotate_narrow_chk: assert property (@(posedge clk) disable iff (!rstN)
    (resultWe && !$past(opSel[2])) |-> (cfWe && ofWe && !sfWe && !zfWe && !afWe && !pfWe));

  // R12
  sign_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    !sfWe |-> $stable(sfOut));

  // R12
  carry_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    !cfWe |-> $stable(cfOut));

endmodule

bind shift_rot_unit sru_checker #(.WIDTH(WIDTH), .IMM_BITS(IMM_BITS)) uChk (
  .clk     (clk),
  .rstN    (rstN),
  .opValid (opValid),
  .opSel   (opSel),
  .cntSrc  (cntSrc),
  .immCount(immCount),
  .result  (result),
  .resultWe(resultWe),
  .cfOut   (cfOut),
  .ofOut   (ofOut),
  .sfOut   (sfOut),
  .afOut   (afOut),
  .cfWe    (cfWe),
  .ofWe    (ofWe),
  .sfWe    (sfWe),
  .zfWe    (zfWe),
  .afWe    (afWe),
  .pfWe    (pfWe)
);

// File: tb/shift_rot_unit_test.sv
`timescale 1ns/1ps
module shift_rot_unit_test;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        opValid = 1'b0;
  logic [2:0]  opSel = '0;
  logic [1:0]  cntSrc = '0;
  logic [7:0]  immCount = '0;
  logic [7:0]  cntReg = '0;
  logic [31:0] operand = '0;
  logic        carryIn = 1'b0;
  logic [31:0] result;
  logic        resultWe;
  logic        cfOut, ofOut, sfOut, zfOut, afOut, pfOut;
  logic        cfWe, ofWe, sfWe, zfWe, afWe, pfWe;

  int total = 0;
  int bad = 0;
  bit finished = 0;

  // bench model state: flags {cf,of,sf,zf,af,pf}
  logic [31:0] expResult = '0;
  logic [5:0]  expFlags = '0;

  always #2.5 clk = ~clk;

  shift_rot_unit uut (
    .clk(clk), .rstN(rstN), .opValid(opValid), .opSel(opSel), .cntSrc(cntSrc),
    .immCount(immCount), .cntReg(cntReg), .operand(operand), .carryIn(carryIn),
    .result(result), .resultWe(resultWe),
    .cfOut(cfOut), .ofOut(ofOut), .sfOut(sfOut), .zfOut(zfOut), .afOut(afOut), .pfOut(pfOut),
    .cfWe(cfWe), .ofWe(ofWe), .sfWe(sfWe), .zfWe(zfWe), .afWe(afWe), .pfWe(pfWe)
  );

  task automatic check(input string req, input string what, input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  function automatic string reqOf(input logic [2:0] op);
    case (op)
      3'b000: return "R4";
      3'b001: return "R5";
      3'b010: return "R6";
      3'b011: return "R7";
      3'b101: return "R9";
      3'b111: return "R10";
      default: return "R8";
    endcase
  endfunction

  // step-by-step reference, one bit position per iteration
  task automatic model(input logic [2:0] op, input int cnt, input logic [31:0] a, input logic cin,
                       output logic [31:0] r, output logic [5:0] fl, output logic [5:0] en, output logic we);
    logic c;
    logic t;
    r = a;
    c = cin;
    fl = expFlags;
    if (cnt == 0) begin
      r = expResult; en = '0; we = 1'b0;
      return;
    end
    we = 1'b1;
    for (int k = 0; k < cnt; k++) begin
      case (op)
        3'b000: r = {r[30:0], r[31]};
        3'b001: r = {r[0], r[31:1]};
        3'b010: begin t = r[31]; r = {r[30:0], c}; c = t; end
        3'b011: begin t = r[0]; r = {c, r[31:1]}; c = t; end
        3'b101: begin c = r[0]; r = {1'b0, r[31:1]}; end
        3'b111: begin c = r[0]; r = {r[31], r[31:1]}; end
        default: begin c = r[31]; r = {r[30:0], 1'b0}; end
      endcase
    end
    case (op)
      3'b000: begin fl[5] = r[0]; fl[4] = r[0] ^ r[31]; end
      3'b001: begin fl[5] = r[31]; fl[4] = r[31] ^ r[30]; end
      3'b010: begin fl[5] = c; fl[4] = c ^ r[31]; end
      3'b011: begin fl[5] = c; fl[4] = r[31] ^ r[30]; end
      3'b101: begin fl[5] = c; fl[4] = a[31]; end
      3'b111: begin fl[5] = c; fl[4] = 1'b0; end
      default: begin fl[5] = c; fl[4] = r[31] ^ c; end
    endcase
    if (op[2]) begin
      fl[3] = r[31];
      fl[2] = (r == 32'h0);
      fl[1] = 1'b0;
      fl[0] = ~^r[7:0];
      en = 6'b111111;
    end else begin
      en = 6'b110000;
    end
  endtask

  // one request; outputs are sampled one negedge later, after the registering edge
  task automatic runOp(input logic [2:0] op, input logic [1:0] src, input logic [7:0] imm,
                       input logic [7:0] creg, input logic [31:0] a, input logic cin, input string req);
    logic [31:0] r;
    logic [5:0]  fl, en;
    logic        we;
    int          cnt;
    cnt = (src == 2'b00) ? int'(imm[4:0]) : (src == 2'b01) ? 1 : int'(creg[4:0]);
    model(op, cnt, a, cin, r, fl, en, we);
    @(negedge clk);
    opSel = op; cntSrc = src; immCount = imm; cntReg = creg; operand = a; carryIn = cin;
    opValid = 1'b1;
    @(negedge clk);
    opValid = 1'b0;
    check(req, "result", 64'(result), 64'(r));
    check(req, "resultWe", 64'(resultWe), 64'(we));
    check(req, "flags", 64'({cfOut, ofOut, sfOut, zfOut, afOut, pfOut}), 64'(fl));
    check((cnt == 0) ? "R2" : "R12", "flag strobes", 64'({cfWe, ofWe, sfWe, zfWe, afWe, pfWe}), 64'(en));
    expResult = r;
    expFlags = fl;
  endtask

  task automatic testReset();
    // R13
    check("R13", "result", 64'(result), 64'h0);
    check("R13", "strobes", 64'({resultWe, cfWe, ofWe, sfWe, zfWe, afWe, pfWe}), 64'h0);
    check("R13", "flags", 64'({cfOut, ofOut, sfOut, zfOut, afOut, pfOut}), 64'h0);
  endtask

  task automatic testSweep();
    // R4 R5 R6 R7 R8 R9 R10 R11: every code, every distance via the count register
    for (int op = 0; op < 8; op++) begin
      for (int c = 0; c < 32; c++) begin
        for (int v = 0; v < 2; v++) begin
          logic [31:0] a;
          a = $urandom();
          a[31] = v[0];
          runOp(3'(op), 2'(2 + v), {3'($urandom()), 5'(c)}, {3'($urandom()), 5'(c)} , a, v[0], reqOf(3'(op)));
        end
      end
    end
  endtask

  task automatic testCountSources();
    // R1: immediate uses low five bits, junk above
    runOp(3'b100, 2'b00, 8'hE3, 8'h07, 32'h0000_0001, 1'b0, "R1");
    check("R1", "imm low bits distance", 64'(result), 64'h8);
    // R1: constant one ignores immediate and register
    runOp(3'b101, 2'b01, 8'h1F, 8'h1F, 32'h8000_0000, 1'b0, "R1");
    check("R1", "forced one distance", 64'(result), 64'h4000_0000);
    // R1: register source with upper junk
    runOp(3'b000, 2'b11, 8'h00, 8'hA4, 32'h0000_0001, 1'b0, "R1");
    check("R1", "register distance", 64'(result), 64'h10);
  endtask

  task automatic testZeroCount();
    // R2: set known flags, then zero distance from both sources
    runOp(3'b100, 2'b01, 8'h00, 8'h00, 32'hC000_0000, 1'b0, "R8");
    runOp(3'b111, 2'b00, 8'hE0, 8'h05, 32'h1234_5678, 1'b1, "R2");
    runOp(3'b010, 2'b10, 8'h07, 8'h20, 32'hFFFF_FFFF, 1'b1, "R2");
    check("R2", "result kept", 64'(result), 64'h8000_0000);
  endtask

  task automatic testShiftFlags();
    // R11: zero result sets ZF, parity of low byte, AF stays 0
    runOp(3'b101, 2'b00, 8'h1F, 8'h00, 32'h0000_00FF, 1'b0, "R11");
    check("R11", "zf", 64'(zfOut), 64'h1);
    runOp(3'b100, 2'b01, 8'h00, 8'h00, 32'h0000_0001, 1'b0, "R11");
    check("R11", "pf odd", 64'(pfOut), 64'h0);
    runOp(3'b111, 2'b01, 8'h00, 8'h00, 32'h8000_0006, 1'b0, "R10");
    check("R10", "sign fill", 64'(result), 64'hC000_0003);
    check("R11", "sf", 64'(sfOut), 64'h1);
  endtask

  task automatic testHold();
    // R12: shift sets SF, following rotate must leave it
    runOp(3'b100, 2'b01, 8'h00, 8'h00, 32'h4000_0000, 1'b0, "R12");
    runOp(3'b001, 2'b01, 8'h00, 8'h00, 32'h0000_0002, 1'b0, "R12");
    check("R12", "sf held after rotate", 64'(sfOut), 64'h1);
    // R6 R7 single-step carry insertion
    runOp(3'b010, 2'b01, 8'h00, 8'h00, 32'h0000_0000, 1'b1, "R6");
    check("R6", "carry at bit 0", 64'(result), 64'h1);
    runOp(3'b011, 2'b01, 8'h00, 8'h00, 32'h0000_0000, 1'b1, "R7");
    check("R7", "carry at bit 31", 64'(result), 64'h8000_0000);
  endtask

  task automatic testIdle();
    // R3: inputs move with no request; nothing changes
    logic [31:0] keepRes;
    logic [5:0]  keepFl;
    keepRes = result;
    keepFl = {cfOut, ofOut, sfOut, zfOut, afOut, pfOut};
    @(negedge clk);
    opSel = 3'b100; cntSrc = 2'b01; operand = 32'hFFFF_FFFF; carryIn = 1'b1; opValid = 1'b0;
    @(negedge clk);
    @(negedge clk);
    check("R3", "idle strobes", 64'({resultWe, cfWe, ofWe, sfWe, zfWe, afWe, pfWe}), 64'h0);
    check("R3", "idle result", 64'(result), 64'(keepRes));
    check("R3", "idle flags", 64'({cfOut, ofOut, sfOut, zfOut, afOut, pfOut}), 64'(keepFl));
  endtask

  initial begin
    repeat (3) @(negedge clk);
    testReset();
    rstN = 1'b1;
    @(negedge clk);
    testReset();
    testCountSources();
    testZeroCount();
    testShiftFlags();
    testHold();
    testIdle();
    testSweep();
    testIdle();
    finished = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      total++;
      bad++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

endmodule